// File: doc/BRIEF.md
# Four-channel prescaled PWM controller

This block generates four independent pulse-width-modulated outputs from one input clock. Software programs it through a small word-addressed register bank on a simple write-strobe bus with a combinational read port. One shared control word holds an enable bit and a 2-bit clock-divide code for every channel. Each channel also has its own configuration word that packs the period length and the high-time length, both counted in divided ticks.

Each channel divides the input clock by 1, 8, 64 or 512, and counts divided ticks from zero up to the end of its period. Its output is high while that count is below the high-time value. Configuration changes made while a channel runs are held back until the current period ends, so a running waveform never produces a truncated or stretched period. A cleared enable bit stops the channel, forces its output low and rewinds it, so that the next enable starts a fresh period.

Top module: `pwm_quad`

## Requirements
- R1: Four channels run independently. Bit n (n = 0..3) of the control word at byte offset 0x0 enables channel n. A channel whose bit is clear keeps its output low whatever the other channels do.
- R2: The divide code of channel n sits in control bits [5+2n:4+2n]. Code 0 gives one tick per input clock, code 1 one tick per 8 clocks, code 2 one per 64 clocks and code 3 one per 512 clocks.
- R3: The configuration word of channel n sits at byte offset 0x4 + 4n. Bits 15:0 hold the period in ticks and bits 31:16 hold the high time in ticks. A period field of 0 means 65536 ticks. The output repeats every period times divide ratio input clocks.
- R4: Within a period the output is high for the first (high time) ticks and low for the rest. A high time of 0 keeps the output constantly low, and a high time equal to or above the period keeps it constantly high.
- R5: The enable bit is sampled on the clock edge after the write that changes it. After a write clears the bit, the output is low from the second edge onward. After a write sets the bit, a new period starts at tick count zero on the second edge.
- R6: Divide-code, period and high-time changes written while a channel runs take effect only at the first edge of the next period. The period already under way finishes with the old values.
- R7: A configuration word reads back all 32 bits as last written. The control word reads back bits 11:0 as last written, and bits 31:12 read as zero.
- R8: A read at an offset that is not word-aligned, or that lies above 0x10, returns zero. A write to such an offset changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 8 | Byte offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current addr, combinational |
| pwm_out | output | 4 | One PWM output per channel, bit n for channel n |

## Verification
The bench programs a changed high time, a changed period and a changed divide code in the middle of a running period. It expects the old waveform up to the period boundary and the new one after it. A design that applied writes at once would show a short or long period at that point. The corner cases are a high time of zero, a high time at or above the period, and the period field of zero meaning 65536 ticks. A design that mishandled the zero field would wrap after one tick or never end its period, and an off-by-one compare would flip the single low cycle at the end of a 65535-of-65536 waveform. Disabling a running channel and enabling it again must restart the count at zero and not resume the old phase. Writes to unaligned and out-of-range offsets must leave every register and output unchanged.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
   // width of one divide-select field in the control word
   localparam int unsigned SEL_W        = 2;
   // first bit of the divide-select fields (enable bits sit below)
   localparam int unsigned CTRL_SEL_LSB = 4;
   // bus data width
   localparam int unsigned WORD_W       = 32;
   // first bit of the high-time field inside a channel word
   localparam int unsigned HIGH_LSB     = 16;

   // prescale counter width: largest ratio is 2**(step*(2**SEL_W - 1))
   function automatic int unsigned pre_width(input int unsigned step_log2);
      return step_log2 * ((1 << SEL_W) - 1);
   endfunction
endpackage

// File: rtl/pwm_quad_presc.sv
module pwm_quad_presc #(
   parameter  int unsigned STEP_LOG2 = 3,
   parameter  int unsigned SEL_W     = 2,
   localparam int unsigned PRE_W     = STEP_LOG2 * ((1 << SEL_W) - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [SEL_W-1:0] sel,
   output logic             tick,
   output logic [PRE_W-1:0] cnt_o
);
   logic [PRE_W:0]   span;
   logic [PRE_W-1:0] lim;
   logic [PRE_W-1:0] cnt_q;

   // ratio = 2**(STEP_LOG2*sel); the counter wraps at ratio-1
   assign span  = (PRE_W+1)'(1) << (STEP_LOG2 * sel);
   assign lim   = PRE_W'(span - (PRE_W+1)'(1));
   assign tick  = (cnt_q == lim);
   assign cnt_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + PRE_W'(1);
      end
   end
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan #(
   parameter  int unsigned CNT_W     = 16,
   parameter  int unsigned STEP_LOG2 = 3,
   parameter  int unsigned SEL_W     = 2,
   parameter  bit          REG_OUT   = 1'b0,
   localparam int unsigned PRE_W     = STEP_LOG2 * ((1 << SEL_W) - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel_in,
   input  logic [CNT_W-1:0] tb_in,
   input  logic [CNT_W-1:0] high_in,
   output logic             pwm,
   output logic             run_o,
   output logic [CNT_W-1:0] per_o,
   output logic [PRE_W-1:0] pre_o,
   output logic [SEL_W-1:0] sh_sel_o,
   output logic [CNT_W-1:0] sh_tb_o,
   output logic [CNT_W-1:0] sh_high_o
);
   logic             run_q;
   logic [SEL_W-1:0] sh_sel_q;
   logic [CNT_W-1:0] sh_tb_q;
   logic [CNT_W-1:0] sh_high_q;
   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] last;
   logic             tick;
   logic             raw;

   pwm_quad_presc #(
      .STEP_LOG2 (STEP_LOG2),
      .SEL_W     (SEL_W)
   ) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (!run_q),
      .sel   (sh_sel_q),
      .tick  (tick),
      .cnt_o (pre_o)
   );

   // a period field of zero wraps to all ones: the full 2**CNT_W ticks
   assign last = sh_tb_q - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         per_q     <= '0;
         sh_sel_q  <= '0;
         sh_tb_q   <= '0;
         sh_high_q <= '0;
      end else begin
         run_q <= en;
         if (!run_q) begin
            // idle: rewind and keep the shadows current
            per_q     <= '0;
            sh_sel_q  <= sel_in;
            sh_tb_q   <= tb_in;
            sh_high_q <= high_in;
         end else if (tick) begin
            if (per_q == last) begin
               per_q     <= '0;
               sh_sel_q  <= sel_in;
               sh_tb_q   <= tb_in;
               sh_high_q <= high_in;
            end else begin
               per_q <= per_q + CNT_W'(1);
            end
         end
      end
   end

   assign raw = run_q && (per_q < sh_high_q);

   generate
      if (REG_OUT) begin : g_reg_out
         logic pwm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pwm_q <= 1'b0;
            else        pwm_q <= raw;
         end
         assign pwm = pwm_q;
      end else begin : g_comb_out
         assign pwm = raw;
      end
   endgenerate

   assign run_o     = run_q;
   assign per_o     = per_q;
   assign sh_sel_o  = sh_sel_q;
   assign sh_tb_o   = sh_tb_q;
   assign sh_high_o = sh_high_q;
endmodule

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
   import pwm_quad_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CNT_W  = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [WORD_W-1:0]                 wdata,
   output logic [WORD_W-1:0]                 rdata,
   output logic [NUM_CH-1:0]                 ch_en,
   output logic [NUM_CH-1:0][SEL_W-1:0]      ch_sel,
   output logic [NUM_CH-1:0][CNT_W-1:0]      ch_tb,
   output logic [NUM_CH-1:0][CNT_W-1:0]      ch_high
);
   localparam int unsigned CTRL_W = CTRL_SEL_LSB + SEL_W * NUM_CH;
   localparam int unsigned IDX_W  = ADDR_W - 2;

   logic [CTRL_W-1:0]              ctrl_q;
   logic [NUM_CH-1:0][WORD_W-1:0]  cfg_all;
   logic [IDX_W-1:0]               idx;
   logic                           aligned;
   logic                           hit_ctrl;
   logic [NUM_CH-1:0]              hit_cfg;

   assign idx      = addr[ADDR_W-1:2];
   assign aligned  = (addr[1:0] == 2'b00);
   assign hit_ctrl = aligned && (idx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ctrl_q <= '0;
      else if (wr_en && hit_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_cfg
      logic [WORD_W-1:0] cfg_r;

      assign hit_cfg[n] = aligned && (idx == IDX_W'(n + 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  cfg_r <= '0;
         else if (wr_en && hit_cfg[n]) cfg_r <= wdata;
      end

      assign cfg_all[n] = cfg_r;
      assign ch_en[n]   = ctrl_q[n];
      assign ch_sel[n]  = ctrl_q[CTRL_SEL_LSB + SEL_W * n +: SEL_W];
      assign ch_tb[n]   = cfg_r[CNT_W-1:0];
      assign ch_high[n] = cfg_r[HIGH_LSB +: CNT_W];
   end

   always_comb begin
      rdata = '0;
      if (hit_ctrl) rdata = WORD_W'(ctrl_q);
      for (int n = 0; n < NUM_CH; n++) begin
         if (hit_cfg[n]) rdata = cfg_all[n];
      end
   end
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
   import pwm_quad_pkg::*;
#(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned STEP_LOG2 = 3,
   parameter bit          REG_OUT   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic [NUM_CH-1:0] pwm_out
);
   localparam int unsigned PRE_W = STEP_LOG2 * ((1 << SEL_W) - 1);

   initial begin
      assert (NUM_CH >= 1 && NUM_CH <= CTRL_SEL_LSB)
         else $fatal(1, "NUM_CH must fit in the enable field");
      assert (CNT_W >= 1 && CNT_W <= HIGH_LSB)
         else $fatal(1, "CNT_W must fit a half word");
      assert (STEP_LOG2 >= 1 && PRE_W <= 24)
         else $fatal(1, "STEP_LOG2 out of range");
      assert (ADDR_W >= 3 && (NUM_CH + 1) <= (1 << (ADDR_W - 2)))
         else $fatal(1, "ADDR_W too small for the register bank");
      assert (CTRL_SEL_LSB + SEL_W * NUM_CH <= WORD_W)
         else $fatal(1, "control word overflow");
   end

   logic [NUM_CH-1:0]             ch_en;
   logic [NUM_CH-1:0][SEL_W-1:0]  ch_sel;
   logic [NUM_CH-1:0][CNT_W-1:0]  ch_tb;
   logic [NUM_CH-1:0][CNT_W-1:0]  ch_high;
   logic [NUM_CH-1:0]             ch_run;
   logic [NUM_CH-1:0][CNT_W-1:0]  ch_per;
   logic [NUM_CH-1:0][PRE_W-1:0]  ch_pre;
   logic [NUM_CH-1:0][SEL_W-1:0]  ch_sh_sel;
   logic [NUM_CH-1:0][CNT_W-1:0]  ch_sh_tb;
   logic [NUM_CH-1:0][CNT_W-1:0]  ch_sh_high;

   pwm_quad_regs #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .ch_en   (ch_en),
      .ch_sel  (ch_sel),
      .ch_tb   (ch_tb),
      .ch_high (ch_high)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      pwm_quad_chan #(
         .CNT_W     (CNT_W),
         .STEP_LOG2 (STEP_LOG2),
         .SEL_W     (SEL_W),
         .REG_OUT   (REG_OUT)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .en        (ch_en[n]),
         .sel_in    (ch_sel[n]),
         .tb_in     (ch_tb[n]),
         .high_in   (ch_high[n]),
         .pwm       (pwm_out[n]),
         .run_o     (ch_run[n]),
         .per_o     (ch_per[n]),
         .pre_o     (ch_pre[n]),
         .sh_sel_o  (ch_sh_sel[n]),
         .sh_tb_o   (ch_sh_tb[n]),
         .sh_high_o (ch_sh_high[n])
      );
   end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
   parameter  int unsigned NUM_CH    = 4,
   parameter  int unsigned ADDR_W    = 8,
   parameter  int unsigned CNT_W     = 16,
   parameter  int unsigned STEP_LOG2 = 3,
   parameter  int unsigned SEL_W     = 2,
   localparam int unsigned PRE_W     = STEP_LOG2 * ((1 << SEL_W) - 1)
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [ADDR_W-1:0]                addr,
   input logic [31:0]                      rdata,
   input logic [NUM_CH-1:0]                pwm_out,
   input logic [NUM_CH-1:0]                ch_en,
   input logic [NUM_CH-1:0]                ch_run,
   input logic [NUM_CH-1:0][CNT_W-1:0]     ch_per,
   input logic [NUM_CH-1:0][PRE_W-1:0]     ch_pre,
   input logic [NUM_CH-1:0][SEL_W-1:0]     ch_sh_sel,
   input logic [NUM_CH-1:0][CNT_W-1:0]     ch_sh_tb,
   input logic [NUM_CH-1:0][CNT_W-1:0]     ch_sh_high
);
   logic mapped;
   assign mapped = (addr[1:0] == 2'b00) &&
                   (addr[ADDR_W-1:2] <= (ADDR_W-2)'(NUM_CH));

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (rdata == 32'd0)); // R8

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic [CNT_W:0] tb_eff;
      logic [PRE_W:0] ratio;

      assign tb_eff = (ch_sh_tb[n] == '0) ? ((CNT_W+1)'(1) << CNT_W)
                                         : {1'b0, ch_sh_tb[n]};
      assign ratio  = (PRE_W+1)'(1) << (STEP_LOG2 * ch_sh_sel[n]);

      AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (!$past(ch_en[n]) && !$past(ch_en[n], 2)) |-> !pwm_out[n]); // R5

      AST_PER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         ch_run[n] |-> ({1'b0, ch_per[n]} < tb_eff)); // R3

      AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         ch_run[n] |-> ({1'b0, ch_pre[n]} < ratio)); // R2

      AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_run[n] && $past(ch_run[n]) && (ch_per[n] != '0 || ch_pre[n] != '0))
         |-> ($stable(ch_sh_high[n]) && $stable(ch_sh_tb[n]) &&
              $stable(ch_sh_sel[n]))); // R6
   end
endmodule

bind pwm_quad pwm_quad_chk #(
   .NUM_CH    (NUM_CH),
   .ADDR_W    (ADDR_W),
   .CNT_W     (CNT_W),
   .STEP_LOG2 (STEP_LOG2)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr       (addr),
   .rdata      (rdata),
   .pwm_out    (pwm_out),
   .ch_en      (ch_en),
   .ch_run     (ch_run),
   .ch_per     (ch_per),
   .ch_pre     (ch_pre),
   .ch_sh_sel  (ch_sh_sel),
   .ch_sh_tb   (ch_sh_tb),
   .ch_sh_high (ch_sh_high)
);

// File: tb/test_pwm_quad.sv
`timescale 1ns/1ps
module test_pwm_quad;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  pwm_out;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 1'b0;

   int m_en[4];
   int m_div[4];
   int m_tb[4];
   int m_high[4];

   always #5 clk = ~clk;

   pwm_quad i_pwm_quad (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .pwm_out (pwm_out)
   );

   task automatic check(input bit ok, input string what, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   // called at a falling edge, returns at the falling edge after the write edge
   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
      addr = '0;
   endtask

   function automatic bit exp_out(input int ch, input int k);
      int r;
      if (m_en[ch] == 0) return 1'b0;
      r = 1 << (3 * m_div[ch]);
      return ((k / r) % m_tb[ch]) < m_high[ch];
   endfunction

   task automatic clear_model();
      for (int c = 0; c < 4; c++) begin
         m_en[c] = 0; m_div[c] = 0; m_tb[c] = 1; m_high[c] = 0;
      end
   endtask

   task automatic set_ch(input int c, input int en, input int dv, input int tb, input int hi);
      m_en[c] = en; m_div[c] = dv; m_tb[c] = tb; m_high[c] = hi;
   endtask

   // disable all, program every channel word, then enable in one write
   task automatic apply_cfg();
      logic [31:0] ctrl;
      bus_wr(8'h00, 32'h0);
      ctrl = '0;
      for (int c = 0; c < 4; c++) begin
         bus_wr(8'(4 + 4 * c), {16'(m_high[c]), 16'(m_tb[c] == 65536 ? 0 : m_tb[c])});
         if (m_en[c] != 0) ctrl[c] = 1'b1;
         ctrl[4 + 2 * c +: 2] = 2'(m_div[c]);
      end
      bus_wr(8'h00, ctrl);
   endtask

   // sample cycle k at the k-th falling edge after the enable write's next edge
   task automatic run_window(input int ncyc, input string tag);
      int bad_k = -1;
      int bad_c = 0;
      bit bad_a = 1'b0;
      bit bad_e = 1'b0;
      for (int k = 0; k < ncyc; k++) begin
         @(negedge clk);
         for (int c = 0; c < 4; c++) begin
            if (bad_k < 0 && pwm_out[c] !== exp_out(c, k)) begin
               bad_k = k; bad_c = c; bad_a = pwm_out[c]; bad_e = exp_out(c, k);
            end
         end
      end
      check(bad_k < 0, $sformatf("%s ch%0d cycle %0d", tag, bad_c, bad_k), bad_a, bad_e);
   endtask

   initial begin
      #(1_950_000);
      n_checks++;
      n_errs++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic [31:0] cfgv[4];
      int win;
      int bad;

      void'($urandom(32'd7391));
      clear_model();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check(pwm_out == 4'h0, "R5 reset outputs low", pwm_out, 0);
      bus_rd(8'h00, rd);
      check(rd == 32'h0, "R7 reset control word", rd, 0);
      bus_rd(8'h0C, rd);
      check(rd == 32'h0, "R7 reset channel word", rd, 0);

      // R7 readback
      bus_wr(8'h0C, 32'hA5A5_1234);
      bus_rd(8'h0C, rd);
      check(rd == 32'hA5A5_1234, "R7 channel word readback", rd, 32'hA5A5_1234);
      bus_wr(8'h00, 32'hFFFF_FFFF);
      bus_rd(8'h00, rd);
      check(rd == 32'h0000_0FFF, "R7 control upper bits zero", rd, 32'h0000_0FFF);
      bus_wr(8'h00, 32'h0000_0AB0);
      bus_rd(8'h00, rd);
      check(rd == 32'h0000_0AB0, "R7 control readback", rd, 32'h0000_0AB0);

      // R8 unmapped offsets
      for (int c = 0; c < 4; c++) begin
         cfgv[c] = 32'h1357_0000 + 32'(c * 32'h0101_0011);
         bus_wr(8'(4 + 4 * c), cfgv[c]);
      end
      bus_wr(8'h14, 32'hDEAD_BEEF);
      bus_wr(8'h06, 32'hFFFF_FFFF);
      bus_wr(8'h01, 32'hFFFF_FFFF);
      bus_wr(8'hFC, 32'h1234_5678);
      bus_rd(8'h14, rd);
      check(rd == 32'h0, "R8 read beyond last channel", rd, 0);
      bus_rd(8'h06, rd);
      check(rd == 32'h0, "R8 unaligned read", rd, 0);
      bus_rd(8'hFC, rd);
      check(rd == 32'h0, "R8 top offset read", rd, 0);
      bus_rd(8'h00, rd);
      check(rd == 32'h0000_0AB0, "R8 control untouched", rd, 32'h0000_0AB0);
      bad = 0;
      for (int c = 0; c < 4; c++) begin
         bus_rd(8'(4 + 4 * c), rd);
         if (rd != cfgv[c]) bad++;
      end
      check(bad == 0, "R8 channel words untouched", bad, 0);
      check(pwm_out == 4'h0, "R8 outputs untouched", pwm_out, 0);

      // R4 high-time extremes
      clear_model();
      set_ch(0, 1, 0, 5, 0);
      set_ch(1, 1, 0, 5, 5);
      set_ch(2, 1, 0, 5, 9);
      set_ch(3, 1, 0, 5, 2);
      apply_cfg();
      run_window(20, "R4 zero and full high time");

      // R2 divide ratios, one per channel
      clear_model();
      for (int c = 0; c < 4; c++) set_ch(c, 1, c, 2, 1);
      apply_cfg();
      run_window(2100, "R2 divide codes 0..3");

      // R1 R2 R3 R4 constrained random
      for (int it = 0; it < 12; it++) begin
         clear_model();
         win = 16;
         for (int c = 0; c < 4; c++) begin
            int dv;
            int tb;
            dv = $urandom_range(0, 3);
            tb = (dv == 3) ? $urandom_range(1, 4) : $urandom_range(1, 12);
            set_ch(c, $urandom_range(0, 1), dv, tb, $urandom_range(0, tb + 2));
         end
         if (m_en[0] + m_en[1] + m_en[2] + m_en[3] == 0) m_en[it % 4] = 1;
         for (int c = 0; c < 4; c++) begin
            if (m_en[c] != 0 && 2 * m_tb[c] * (1 << (3 * m_div[c])) > win)
               win = 2 * m_tb[c] * (1 << (3 * m_div[c]));
         end
         apply_cfg();
         run_window(win, $sformatf("R1 R3 R4 random set %0d", it));
      end

      // R3 period field zero means 65536 ticks
      clear_model();
      set_ch(0, 1, 0, 65536, 65535);
      apply_cfg();
      run_window(65540, "R3 full-length period");

      // R6 mid-period changes wait for the boundary
      clear_model();
      set_ch(1, 1, 0, 4, 1);
      apply_cfg();
      bad = -1;
      for (int k = 0; k < 4 + 96; k++) begin
         bit e;
         @(negedge clk);
         e = (k < 4) ? ((k % 4) < 1) : ((((k - 4) / 8) % 6) < 3);
         if (bad < 0 && pwm_out[1] !== e) bad = k;
         if (k == 1) begin
            wr_en = 1'b1; addr = 8'h08; wdata = {16'd3, 16'd6};
         end else if (k == 2) begin
            addr = 8'h00; wdata = 32'h0000_0042;
         end else if (k == 3) begin
            wr_en = 1'b0; addr = '0; wdata = '0;
         end
      end
      check(bad < 0, "R6 shadowed update first wrong cycle", bad, -1);

      // R5 disable forces low, enable restarts from zero
      clear_model();
      set_ch(0, 1, 0, 4, 2);
      apply_cfg();
      run_window(6, "R5 running before disable");
      bus_wr(8'h00, 32'h0);
      bad = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (pwm_out !== 4'h0) bad++;
      end
      check(bad == 0, "R5 low after disable", bad, 0);
      bus_wr(8'h00, 32'h1);
      run_window(12, "R5 restart from count zero");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end
endmodule